// File: doc/BRIEF.md
# Speaker Gate and Status Port

This block is a byte-wide I/O register for a PC-style system. Software writes it to open or close the gate of timer channel 2 and to allow or block the speaker data path. Reading it returns those two control bits, the level the timer channel currently drives, and a refresh indicator. The timer and any sound generation sit outside the block. The timer level arrives as a plain input.

Access uses a simple slave interface. An address decoder outside the block raises a chip-select strobe. Separate read and write enables qualify that strobe. Write data and read data are 8 bits each. Both control outputs and the read data bus are registered. The value of an accepted read appears on the clock edge that samples it.

The refresh indicator does not run from a clock. It inverts once for each accepted read, so back-to-back reads return opposite values in that bit.

Top module: `spk_gate_port`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, tmr2_gate, spk_data_en and rd_data are all 0, and the refresh state is cleared.
- R2: An accepted write (cs and wr_en high at a clock edge) sets tmr2_gate to bit 0 of wr_data from that edge onward. With no accepted write, tmr2_gate holds.
- R3: An accepted write sets spk_data_en to bit 1 of wr_data from that edge onward. With no accepted write, spk_data_en holds.
- R4: An accepted read (cs and rd_en high at a clock edge) drives rd_data after that edge with bit 0 equal to the gate value and bit 1 equal to the data-enable value held before the edge.
- R5: Bit 5 of the value returned by an accepted read equals the level of tmr2_lvl at the sampling edge.
- R6: Bit 4 of the value returned by an accepted read is 1 on the first read after reset and inverts on every later accepted read. Back-to-back reads alternate.
- R7: Bits 2, 3, 6 and 7 of rd_data are always 0. Write data bits 2 to 7 have no effect.
- R8: When cs is low at an edge, rd_data is 0 after that edge. The gate and data-enable values do not change. The refresh bit does not advance.
- R9: When read and write are both accepted at the same edge, the returned value holds the control bits from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Address-match strobe for this port |
| rd_en | input | 1 | Read enable, qualified by cs |
| wr_en | input | 1 | Write enable, qualified by cs |
| wr_data | input | 8 | Write data byte |
| tmr2_lvl | input | 1 | Present output level of timer channel 2 |
| rd_data | output | 8 | Registered read data; 0 when no read was accepted |
| tmr2_gate | output | 1 | Gate level for timer channel 2 |
| spk_data_en | output | 1 | Speaker data enable |

## Verification
A corrupted control flop shows on tmr2_gate or spk_data_en one edge after the write that should have set it. The next accepted read also reports it in bit 0 or 1. A refresh flop that sticks, or that advances on unselected cycles, only shows across two accepted reads. For that reason the bench issues reads back to back and around ignored cycles, and predicts bit 4 for every read. A late or missing read enable shows as a zero or stale byte exactly one edge after the strobe.

// File: rtl/spk_port_pkg.sv
package spk_port_pkg;
  // Bit positions decoded by software; keep them fixed.
  localparam int unsigned POS_GATE = 0;
  localparam int unsigned POS_SPK  = 1;
  localparam int unsigned POS_REFR = 4;
  localparam int unsigned POS_TMR  = 5;
  localparam int unsigned MIN_W    = POS_TMR + 1;
endpackage

// File: rtl/spk_ctrl_reg.sv
module spk_ctrl_reg
  import spk_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic gate_d,
  input  logic spk_d,
  output logic gate_q,
  output logic spk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (wr_stb) begin
      gate_q <= gate_d;
      spk_q  <= spk_d;
    end
  end
endmodule

// File: rtl/spk_refresh_tog.sv
module spk_refresh_tog (
  input  logic clk,
  input  logic rst,
  input  logic rd_stb,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (rst)         tog_q <= 1'b0;
    else if (rd_stb) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/spk_rd_mux.sv
module spk_rd_mux
  import spk_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              gate,
  input  logic              spk,
  input  logic              tog,
  input  logic              tmr,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word           = '0;
    word[POS_GATE] = gate;
    word[POS_SPK]  = spk;
    word[POS_REFR] = ~tog;   // reported value is the post-read phase
    word[POS_TMR]  = tmr;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (rd_stb) rd_q <= word;
    else             rd_q <= '0;
  end
endmodule

// File: rtl/spk_gate_port.sv
module spk_gate_port
  import spk_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tmr2_lvl,
  output logic [DATA_W-1:0] rd_data,
  output logic              tmr2_gate,
  output logic              spk_data_en
);
  localparam int unsigned SPARE_W = DATA_W - (POS_SPK + 1);

  logic rd_stb, wr_stb, tog;
  logic [SPARE_W-1:0] unused_wr;

  assign rd_stb    = cs & rd_en;
  assign wr_stb    = cs & wr_en;
  assign unused_wr = wr_data[DATA_W-1:POS_SPK+1];

  spk_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .gate_d (wr_data[POS_GATE]),
    .spk_d  (wr_data[POS_SPK]),
    .gate_q (tmr2_gate),
    .spk_q  (spk_data_en)
  );

  spk_refresh_tog u_tog (
    .clk    (clk),
    .rst    (rst),
    .rd_stb (rd_stb),
    .tog_q  (tog)
  );

  spk_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .rd_stb (rd_stb),
    .gate   (tmr2_gate),
    .spk    (spk_data_en),
    .tog    (tog),
    .tmr    (tmr2_lvl),
    .rd_q   (rd_data)
  );
endmodule

// File: rtl/spk_gate_port_chk.sv
module spk_gate_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rd_en,
  input logic              wr_en,
  input logic [1:0]        wr_lo,
  input logic              tmr2_lvl,
  input logic [DATA_W-1:0] rd_data,
  input logic              tmr2_gate,
  input logic              spk_data_en
);
  logic rd_prev, have_prev, last_b4;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev   <= 1'b0;
      have_prev <= 1'b0;
      last_b4   <= 1'b0;
    end else begin
      rd_prev <= cs & rd_en;
      if (rd_prev) begin
        have_prev <= 1'b1;
        last_b4   <= rd_data[4];
      end
    end
  end

  a_r2_gate_write: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en) |=> (tmr2_gate == $past(wr_lo[0])));
  a_r2_gate_hold: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr_en) |=> $stable(tmr2_gate));
  a_r3_en_write: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en) |=> (spk_data_en == $past(wr_lo[1])));
  a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr_en) |=> $stable(spk_data_en));
  a_r4_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (cs && rd_en) |=> (rd_data[1:0] == {$past(spk_data_en), $past(tmr2_gate)}));
  a_r5_timer_level: assert property (@(posedge clk) disable iff (rst)
    (cs && rd_en) |=> (rd_data[5] == $past(tmr2_lvl)));
  a_r6_first_read_one: assert property (@(posedge clk) disable iff (rst)
    (rd_prev && !have_prev) |-> rd_data[4]);
  a_r6_alternates: assert property (@(posedge clk) disable iff (rst)
    (rd_prev && have_prev) |-> (rd_data[4] != last_b4));
  a_r7_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3:2] == 2'b00) && (rd_data[DATA_W-1:6] == '0));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd_en) |=> (rd_data == '0));
endmodule

bind spk_gate_port spk_gate_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs          (cs),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .wr_lo       (wr_data[1:0]),
  .tmr2_lvl    (tmr2_lvl),
  .rd_data     (rd_data),
  .tmr2_gate   (tmr2_gate),
  .spk_data_en (spk_data_en)
);

// File: tb/tb_spk_gate_port.sv
`timescale 1ns/1ps
module tb_spk_gate_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0, tmr2_lvl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tmr2_gate, spk_data_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic m_gate = 1'b0, m_en = 1'b0, m_tog = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  spk_gate_port dut (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .tmr2_lvl(tmr2_lvl), .rd_data(rd_data),
    .tmr2_gate(tmr2_gate), .spk_data_en(spk_data_en)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // driver: one cycle of bus activity, pushes the expected read byte
  task automatic xfer(input bit s, input bit r, input bit w, input logic [7:0] d, input bit t);
    @(negedge clk);
    cs = s; rd_en = r; wr_en = w; wr_data = d; tmr2_lvl = t;
    if (s && r) begin
      exp_q.push_back({2'b00, t, ~m_tog, 2'b00, m_en, m_gate});
      m_tog = ~m_tog;
    end
    if (s && w) begin
      m_gate = d[0];
      m_en   = d[1];
    end
  endtask

  // drop the bus and check the control outputs (R2, R3)
  task automatic idle();
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    check(tmr2_gate == m_gate, "R2 gate", {7'b0, tmr2_gate}, {7'b0, m_gate});
    check(spk_data_en == m_en, "R3 data enable", {7'b0, spk_data_en}, {7'b0, m_en});
  endtask

  // monitor: compares each result against the scoreboard
  initial begin
    forever begin
      bit took, in_rst;
      @(posedge clk);
      took = cs && rd_en;
      in_rst = rst;
      @(negedge clk);
      if (!in_rst) begin
        if (took) begin
          if (exp_q.size() == 0) check(1'b0, "R4 unexpected read", rd_data, 8'h00);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R4/R5/R6/R7/R9 read value", rd_data, e);
          end
        end else begin
          check(rd_data == 8'h00, "R8 idle bus zero", rd_data, 8'h00);
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=00 expected=01");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 8'h00);
    check(tmr2_gate == 1'b0, "R1 reset gate", {7'b0, tmr2_gate}, 8'h00);
    check(spk_data_en == 1'b0, "R1 reset enable", {7'b0, spk_data_en}, 8'h00);
    rst = 1'b0;
    idle();
    // R1, R6: first read after reset shows refresh bit 1
    xfer(1, 1, 0, 8'h00, 0);
    idle();
    // R2, R3: set both bits; R4 readback
    xfer(1, 0, 1, 8'h03, 0);
    idle();
    xfer(1, 1, 0, 8'h00, 0);
    idle();
    // R7: upper write bits ignored, only gate set
    xfer(1, 0, 1, 8'hFD, 0);
    idle();
    xfer(1, 1, 0, 8'h00, 1);   // R5 timer high
    idle();
    // R3 alone
    xfer(1, 0, 1, 8'hFE, 0);
    idle();
    // R6: back-to-back reads, R5 varying level
    xfer(1, 1, 0, 8'h00, 1);
    xfer(1, 1, 0, 8'h00, 0);
    xfer(1, 1, 0, 8'h00, 1);
    idle();
    // R8: unselected write and read have no effect
    xfer(0, 0, 1, 8'h01, 1);
    idle();
    xfer(0, 1, 0, 8'h00, 1);
    idle();
    xfer(0, 1, 1, 8'h03, 0);
    idle();
    xfer(1, 1, 0, 8'h00, 0);   // refresh bit proves no advance under R8
    idle();
    // R9: simultaneous read and write reports prior control bits
    xfer(1, 1, 1, 8'h01, 1);
    idle();
    xfer(1, 1, 1, 8'h02, 0);
    xfer(1, 1, 0, 8'h00, 1);
    idle();
    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_gate = 1'b0; m_en = 1'b0; m_tog = 1'b0;
    check(tmr2_gate == 1'b0 && spk_data_en == 1'b0, "R1 re-reset outputs",
          {6'b0, spk_data_en, tmr2_gate}, 8'h00);
    xfer(1, 1, 0, 8'h00, 0);
    idle();
    idle();
    check(exp_q.size() == 0, "R4 all reads returned", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    finish_run();
  end
endmodule